// File: doc/BRIEF.md
# Ethernet MAC Statistics Counter Bank

This block keeps the frame and octet statistics of one Ethernet MAC port, one set for receive and one for transmit. The MAC datapath sends one single-cycle event per finished frame in each direction. The event carries the frame length and a set of classification flags. The bank updates a total frame count, a total octet count, one count for each flag and a seven-bin length histogram. Software reads the counters one word at a time through a simple read port. Every counter read clears that counter, so software can add each value it reads to a running total of its own.

The total frame and total octet counts are wider than the read word, so each is read as a low word followed by a high word. Reading the low word takes a snapshot of the upper bits into a shadow register. A later high-word read returns that snapshot, so the two halves always belong to the same count. Counters stop at their maximum value instead of wrapping, so an overflow between two reads stays visible. A single clear-all input zeroes the whole bank.

Top module: `mac_stat_bank`

## Requirements
- R1: After reset, and in the cycle after `clear_all` is high, every counter and every high-word shadow reads zero. `clear_all` wins over a frame event in the same cycle.
- R2: Each event in a direction adds one to that direction's total frame count and adds the event length to its total octet count. Low words are at local address 0 (frames) and 2 (octets).
- R3: A low-word read loads the bits above the word width into a shadow. Local address 1 (frames) and 3 (octets) return that shadow, zero-extended, and reading them clears nothing.
- R4: A read issued with `rd_en` returns its data on `rd_data` with `rd_valid` high one cycle later. Every counter that is read is cleared.
- R5: Receive flag bits are counted only with an event: bit0 multicast (addr 4), bit1 broadcast (5), bit2 pause (6), bit3 FCS error (7), bit4 short (8), bit5 jabber (9), bit6 oversize (10), bit7 symbol error (11).
- R6: Transmit flag bits are counted only with an event: bit0 multicast (addr 36), bit1 broadcast (37), bit2 pause (38), bit3 error frame, covering bad FCS or underrun (39).
- R7: Each event adds one to exactly one length bin, at local addresses 16 to 22: length <=64, 65-127, 128-255, 256-511, 512-1023, 1024-1518, and >=1519.
- R8: A counter that reaches its all-ones maximum stays at that value until it is read or cleared.
- R9: When a read and an event hit the same counter in the same cycle, the read returns the value from before the event. The counter is then left holding that event's increment.
- R10: `rd_addr[5]` selects transmit (1) or receive (0). A local address that holds no counter reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_all | input | 1 | Zero every counter and shadow |
| rx_evt | input | 1 | Receive frame-end event |
| rx_len | input | LEN_W | Receive frame length in octets |
| rx_flags | input | 8 | Receive classification flags |
| tx_evt | input | 1 | Transmit frame-end event |
| tx_len | input | LEN_W | Transmit frame length in octets |
| tx_flags | input | 4 | Transmit classification flags |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 6 | Direction bit and local word address |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | WORD_W | Read data |

## Verification
A counter that is missed or doubled shows up as a wrong word on the first read of that address after the event. Each batch of events is followed by a read of every address, so such an error is caught within one batch. A shadow that is stale or torn shows up as a wrong high word on the read just after the low-word read. A clear that went to the wrong counter shows up two reads later: the counter it hit reads short, and the counter it missed reads a count that should have been cleared. A saturation or same-cycle fault changes the value read at the next access of that one counter.

// File: rtl/stat_pkg.sv
package stat_pkg;
  localparam int NUM_BINS     = 7;
  localparam int NUM_RX_FLAGS = 8;
  localparam int NUM_TX_FLAGS = 4;
  localparam int LOC_FRM_LO   = 0;
  localparam int LOC_FRM_HI   = 1;
  localparam int LOC_BYT_LO   = 2;
  localparam int LOC_BYT_HI   = 3;
  localparam int LOC_FLAG0    = 4;
  localparam int LOC_BIN0     = 16;

  // length histogram bin for one frame (R7)
  function automatic logic [2:0] len_bin(input logic [31:0] len);
    if (len <= 32'd64)        return 3'd0;
    else if (len <= 32'd127)  return 3'd1;
    else if (len <= 32'd255)  return 3'd2;
    else if (len <= 32'd511)  return 3'd3;
    else if (len <= 32'd1023) return 3'd4;
    else if (len <= 32'd1518) return 3'd5;
    else                      return 3'd6;
  endfunction
endpackage

// File: rtl/stat_cnt.sv
module stat_cnt #(
  parameter int W  = 32,
  parameter int IW = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_all,
  input  logic          hit,
  input  logic [IW-1:0] inc,
  input  logic          rd_clr,
  output logic [W-1:0]  value
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic [W:0]   sum;
  logic [W-1:0] nxt;
  wire          at_max = (value == CNT_MAX);

  always_comb begin
    sum = {1'b0, value} + (W+1)'(inc);
    nxt = sum[W] ? CNT_MAX : sum[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          value <= '0;
    else if (clr_all)    value <= '0;
    else if (rd_clr)     value <= hit ? W'(inc) : '0;   // R9 reload
    else if (hit)        value <= nxt;
  end

  assert_clear_all_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> value == '0);
  assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (at_max && !rd_clr && !clr_all) |=> value == CNT_MAX);
  assert_monotonic_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_clr && !clr_all) |=> value >= $past(value));
  assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !hit) |=> value == '0);
endmodule

// File: rtl/stat_dir.sv
module stat_dir
  import stat_pkg::*;
#(
  parameter int NFLAG  = 8,
  parameter int CNT_W  = 32,
  parameter int TOTF_W = 36,
  parameter int BYTE_W = 45,
  parameter int LEN_W  = 14,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_all,
  input  logic              evt,
  input  logic [LEN_W-1:0]  len,
  input  logic [NFLAG-1:0]  flags,
  input  logic              rd_sel,
  input  logic [4:0]        rd_loc,
  output logic [WORD_W-1:0] rd_word
);
  localparam int HF_W = TOTF_W - WORD_W;
  localparam int HB_W = BYTE_W - WORD_W;

  logic [TOTF_W-1:0] frm_val;
  logic [BYTE_W-1:0] byt_val;
  logic [HF_W-1:0]   sh_frm;
  logic [HB_W-1:0]   sh_byt;
  logic [CNT_W-1:0]  flag_val [NFLAG];
  logic [CNT_W-1:0]  bin_val  [NUM_BINS];

  wire [2:0] ev_bin  = len_bin(32'(len));
  wire       clr_frm = rd_sel && (rd_loc == 5'(LOC_FRM_LO));
  wire       clr_byt = rd_sel && (rd_loc == 5'(LOC_BYT_LO));
  wire       loc_used = (rd_loc < 5'(LOC_FLAG0 + NFLAG)) ||
                        ((rd_loc >= 5'(LOC_BIN0)) && (rd_loc < 5'(LOC_BIN0 + NUM_BINS)));

  stat_cnt #(.W(TOTF_W), .IW(1)) u_frm (
    .clk(clk), .rst_n(rst_n), .clr_all(clr_all), .hit(evt), .inc(1'b1),
    .rd_clr(clr_frm), .value(frm_val));

  stat_cnt #(.W(BYTE_W), .IW(LEN_W)) u_byt (
    .clk(clk), .rst_n(rst_n), .clr_all(clr_all), .hit(evt), .inc(len),
    .rd_clr(clr_byt), .value(byt_val));

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    wire f_hit = evt && flags[i];
    wire f_clr = rd_sel && (rd_loc == 5'(LOC_FLAG0 + i));
    stat_cnt #(.W(CNT_W), .IW(1)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr_all(clr_all), .hit(f_hit), .inc(1'b1),
      .rd_clr(f_clr), .value(flag_val[i]));
  end

  for (genvar b = 0; b < NUM_BINS; b++) begin : g_bin
    wire b_hit = evt && (ev_bin == 3'(b));
    wire b_clr = rd_sel && (rd_loc == 5'(LOC_BIN0 + b));
    stat_cnt #(.W(CNT_W), .IW(1)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr_all(clr_all), .hit(b_hit), .inc(1'b1),
      .rd_clr(b_clr), .value(bin_val[b]));
  end

  // high-word shadows, loaded on the low-word read (R3)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_frm <= '0;
      sh_byt <= '0;
    end else if (clr_all) begin
      sh_frm <= '0;
      sh_byt <= '0;
    end else begin
      if (clr_frm) sh_frm <= frm_val[TOTF_W-1:WORD_W];
      if (clr_byt) sh_byt <= byt_val[BYTE_W-1:WORD_W];
    end
  end

  always_comb begin
    rd_word = '0;
    if (rd_loc == 5'(LOC_FRM_LO)) rd_word = frm_val[WORD_W-1:0];
    if (rd_loc == 5'(LOC_FRM_HI)) rd_word = WORD_W'(sh_frm);
    if (rd_loc == 5'(LOC_BYT_LO)) rd_word = byt_val[WORD_W-1:0];
    if (rd_loc == 5'(LOC_BYT_HI)) rd_word = WORD_W'(sh_byt);
    for (int i = 0; i < NFLAG; i++)
      if (rd_loc == 5'(LOC_FLAG0 + i)) rd_word = WORD_W'(flag_val[i]);
    for (int b = 0; b < NUM_BINS; b++)
      if (rd_loc == 5'(LOC_BIN0 + b)) rd_word = WORD_W'(bin_val[b]);
  end

  assert_unused_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel && !loc_used) |-> rd_word == '0);
  assert_shadow_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (sh_frm == '0 && sh_byt == '0));
  assert_shadow_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_all && !clr_byt) |=> $stable(sh_byt));
endmodule

// File: rtl/mac_stat_bank.sv
module mac_stat_bank
  import stat_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int TOTF_W = 36,
  parameter int BYTE_W = 45,
  parameter int LEN_W  = 14,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_all,
  input  logic              rx_evt,
  input  logic [LEN_W-1:0]  rx_len,
  input  logic [7:0]        rx_flags,
  input  logic              tx_evt,
  input  logic [LEN_W-1:0]  tx_len,
  input  logic [3:0]        tx_flags,
  input  logic              rd_en,
  input  logic [5:0]        rd_addr,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data
);
  logic [WORD_W-1:0] rx_word, tx_word;
  wire               rd_tx  = rd_addr[5];
  wire               rx_sel = rd_en && !rd_tx;
  wire               tx_sel = rd_en && rd_tx;

  stat_dir #(.NFLAG(NUM_RX_FLAGS), .CNT_W(CNT_W), .TOTF_W(TOTF_W),
             .BYTE_W(BYTE_W), .LEN_W(LEN_W), .WORD_W(WORD_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .clr_all(clear_all), .evt(rx_evt), .len(rx_len),
    .flags(rx_flags), .rd_sel(rx_sel), .rd_loc(rd_addr[4:0]), .rd_word(rx_word));

  stat_dir #(.NFLAG(NUM_TX_FLAGS), .CNT_W(CNT_W), .TOTF_W(TOTF_W),
             .BYTE_W(BYTE_W), .LEN_W(LEN_W), .WORD_W(WORD_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .clr_all(clear_all), .evt(tx_evt), .len(tx_len),
    .flags(tx_flags), .rd_sel(tx_sel), .rd_loc(rd_addr[4:0]), .rd_word(tx_word));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_tx ? tx_word : rx_word;
    end
  end

  assert_valid_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  assert_data_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

// File: tb/sim_mac_stat_bank.sv
module sim_mac_stat_bank;
  localparam int CLK_P  = 10;
  localparam int CNT_W  = 8;
  localparam int TOTF_W = 20;
  localparam int BYTE_W = 29;
  localparam int LEN_W  = 14;
  localparam int WORD_W = 16;
  localparam longint unsigned WMASK = (64'd1 << WORD_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0, clear_all = 1'b0;
  logic rx_evt = 1'b0, tx_evt = 1'b0, rd_en = 1'b0;
  logic [LEN_W-1:0] rx_len = '0, tx_len = '0;
  logic [7:0] rx_flags = '0;
  logic [3:0] tx_flags = '0;
  logic [5:0] rd_addr = '0;
  logic rd_valid;
  logic [WORD_W-1:0] rd_data;

  int checks = 0, failures = 0;
  longint unsigned m  [2][32];
  longint unsigned sh [2][2];

  always #(CLK_P/2) clk = ~clk;

  mac_stat_bank #(.CNT_W(CNT_W), .TOTF_W(TOTF_W), .BYTE_W(BYTE_W),
                  .LEN_W(LEN_W), .WORD_W(WORD_W)) u0 (
    .clk(clk), .rst_n(rst_n), .clear_all(clear_all), .rx_evt(rx_evt),
    .rx_len(rx_len), .rx_flags(rx_flags), .tx_evt(tx_evt), .tx_len(tx_len),
    .tx_flags(tx_flags), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data));

  function automatic longint unsigned sat(longint unsigned v, longint unsigned inc, int w);
    longint unsigned top = (64'd1 << w) - 1;
    return (v + inc > top) ? top : v + inc;
  endfunction

  function automatic int bin_of(int len);
    int bounds [6] = '{64, 127, 255, 511, 1023, 1518};
    int idx = 0;
    foreach (bounds[k]) if (len > bounds[k]) idx++;
    return idx;
  endfunction

  function automatic int nflags(int d);
    return (d == 0) ? 8 : 4;
  endfunction

  function automatic bit is_cnt(int d, int l);
    return (l == 0) || (l == 2) || (l >= 4 && l < 4 + nflags(d)) || (l >= 16 && l <= 22);
  endfunction

  function automatic string tag_of(int d, int l);
    if (l == 0 || l == 2) return "R2";
    if (l == 1 || l == 3) return "R3";
    if (l >= 16 && l <= 22) return "R7";
    if (is_cnt(d, l)) return (d == 0) ? "R5" : "R6";
    return "R10";
  endfunction

  task automatic chk(bit ok, string tag, longint unsigned act, longint unsigned exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int d = 0; d < 2; d++) begin
      for (int l = 0; l < 32; l++) m[d][l] = 0;
      sh[d][0] = 0;
      sh[d][1] = 0;
    end
  endtask

  task automatic model_evt(int d, int len, logic [7:0] f);
    m[d][0] = sat(m[d][0], 1, TOTF_W);
    m[d][2] = sat(m[d][2], len, BYTE_W);
    for (int i = 0; i < nflags(d); i++)
      if (f[i]) m[d][4+i] = sat(m[d][4+i], 1, CNT_W);
    m[d][16 + bin_of(len)] = sat(m[d][16 + bin_of(len)], 1, CNT_W);
  endtask

  // one clock: drive at negedge, check the read at the next negedge
  task automatic cyc(logic rxe, int rxl, logic [7:0] rxf, logic txe, int txl,
                     logic [3:0] txf, logic rde, int addr, logic clr);
    longint unsigned exp = 0;
    int d = addr / 32;
    int l = addr % 32;
    rx_evt = rxe; rx_len = LEN_W'(rxl); rx_flags = rxf;
    tx_evt = txe; tx_len = LEN_W'(txl); tx_flags = txf;
    rd_en = rde; rd_addr = 6'(addr); clear_all = clr;
    if (rde) begin
      if (l == 1 || l == 3) exp = sh[d][l/2];
      else if (is_cnt(d, l)) begin
        exp = m[d][l];
        if (l == 0 || l == 2) begin
          sh[d][l/2] = exp >> WORD_W;
          exp = exp & WMASK;
        end
        m[d][l] = 0;
      end
    end
    if (clr) model_clear();
    else begin
      if (rxe) model_evt(0, rxl, rxf);
      if (txe) model_evt(1, txl, {4'b0, txf});
    end
    @(negedge clk);
    rx_evt = 0; tx_evt = 0; rd_en = 0; clear_all = 0;
    if (rde) begin
      chk(rd_valid === 1'b1, "R4", rd_valid, 1);
      chk(rd_data === WORD_W'(exp), tag_of(d, l), rd_data, exp);
    end
  endtask

  task automatic read_all();
    for (int a = 0; a < 64; a++) cyc(0, 0, 0, 0, 0, 0, 1, a, 0);
  endtask

  task automatic idle_cycle();
    cyc(0, 0, 8'($urandom), 0, 0, 4'($urandom), 0, 0, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL R4 watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    read_all();
    idle_cycle();
    chk(rd_valid === 1'b0, "R4", rd_valid, 0);

    // R7: directed length boundaries in both directions
    begin
      int lens [13] = '{63, 64, 65, 127, 128, 255, 256, 511, 512, 1023, 1024, 1518, 1519};
      foreach (lens[k]) cyc(1, lens[k], 8'h01, 1, lens[k], 4'h8, 0, 0, 0);
    end
    read_all();
    chk(rd_valid === 1'b1, "R4", rd_valid, 1);

    // R2 R3 R5 R6 R7 R10: random batches, flags also toggle with no event
    for (int b = 0; b < 20; b++) begin
      int n = 5 + int'($urandom % 26);
      for (int k = 0; k < n; k++) begin
        cyc(1'($urandom % 3 != 0), 40 + int'($urandom % 9000), 8'($urandom),
            1'($urandom % 3 != 0), 40 + int'($urandom % 9000), 4'($urandom),
            0, 0, 0);
        if ($urandom % 4 == 0) idle_cycle();
      end
      read_all();
    end

    // R8: saturation of an 8-bit flag counter
    for (int k = 0; k < 300; k++) cyc(1, 64, 8'h01, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 1, 4, 0);
    chk(rd_data === WORD_W'(255), "R8", rd_data, 255);
    read_all();

    // R9: read and event on the same counter in one cycle
    for (int k = 0; k < 3; k++) cyc(1, 100, 8'h02, 0, 0, 0, 0, 0, 0);
    cyc(1, 100, 8'h02, 0, 0, 0, 1, 0, 0);
    chk(rd_data === WORD_W'(3), "R9", rd_data, 3);
    cyc(1, 200, 8'h02, 0, 0, 0, 1, 5, 0);
    cyc(0, 0, 0, 0, 0, 0, 1, 0, 0);
    chk(rd_data === WORD_W'(2), "R9", rd_data, 2);
    cyc(0, 0, 0, 0, 0, 0, 1, 5, 0);
    chk(rd_data === WORD_W'(1), "R9", rd_data, 1);
    read_all();

    // R1: clear_all wins over same-cycle events and zeroes shadows
    for (int k = 0; k < 20; k++) cyc(1, 9000, 8'hFF, 1, 9000, 4'hF, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 1, 2, 0);
    cyc(1, 500, 8'hFF, 1, 500, 4'hF, 0, 0, 1);
    read_all();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule